// File: doc/BRIEF.md
# Accumulator ALU with Carry/Borrow Flag

This block is the execution stage of a small accumulator machine. Each cycle it takes the present accumulator, one register operand, the present carry/borrow flag and a 4-bit operation code. It then produces the next accumulator value, the next flag, the value for an extension register that catches the upper half of a product, and one write-enable for each of those three destinations. Register selection, sequencing and branching are handled outside.

Every operation follows its own rule for the flag. Arithmetic writes the carry or the borrow. Compare writes only the flag. Logic and shift operations leave the flag alone. Multiply splits a double-width product across the accumulator and the extension register. Register moves into the accumulator pass through here, so the core has a single result path.

The outputs are registered. The results for inputs sampled at one rising clock edge appear after that edge, and the write-enables mark which of them the core should commit. Every width is set by the parameter `WIDTH`, which defaults to 8.

Top module: `acc_alu`

## Requirements
- R1: A synchronous active-high `rst` clears all three write-enables and drives `acc_o`, `flag_o` and `ext_o` to zero. Outside reset, the results for the inputs sampled at a rising edge appear on the outputs after that edge.
- R2: Code 1 (add) gives `acc_o` = (acc_i + reg_i) mod 256 and `flag_o` = carry out of bit 7. It asserts `acc_we_o` and `flag_we_o`.
- R3: Code 2 (subtract) gives `acc_o` = (acc_i − reg_i) mod 256 and `flag_o` = 1 exactly when reg_i > acc_i (unsigned). It asserts `acc_we_o` and `flag_we_o`.
- R4: Code 3 (multiply) puts the low byte of the 16-bit product in `acc_o` and the high byte in `ext_o`. It asserts `acc_we_o` and `ext_we_o`, and `flag_we_o` stays low.
- R5: Code 4 gives the bitwise AND and code 5 the bitwise XOR of acc_i and reg_i in `acc_o`. Only `acc_we_o` is asserted.
- R6: Code 6 (compare) asserts only `flag_we_o`. It sets `flag_o` = 1 exactly when acc_i < reg_i (unsigned), and `acc_o` equals acc_i.
- R7: Code 7 (increment) and code 8 (decrement) write acc_i ± 1 mod 256. The flag is 1 only when the value wraps: 0xFF to 0x00 for increment, 0x00 to 0xFF for decrement. `acc_we_o` and `flag_we_o` are asserted.
- R8: Code 9 shifts left and code 10 shifts right, each filling with zero. Only `acc_we_o` is asserted.
- R9: Code 11 rotates right (bit 0 enters bit 7) and code 12 rotates left (bit 7 enters bit 0). Only `acc_we_o` is asserted.
- R10: Code 13 shifts right and copies bit 7 into the vacated top bit. Only `acc_we_o` is asserted.
- R11: Code 14 (move into accumulator) gives `acc_o` = reg_i with only `acc_we_o` asserted.
- R12: Codes 0 and 15 assert no write-enable.
- R13: Whenever `flag_we_o` is low outside reset, `flag_o` equals the flag_i that was sampled. Whenever `acc_we_o` is low, `acc_o` equals the sampled acc_i. Whenever `ext_we_o` is low, `ext_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| acc_i | input | WIDTH | Current accumulator |
| reg_i | input | WIDTH | Register operand |
| flag_i | input | 1 | Current carry/borrow flag |
| acc_o | output | WIDTH | Next accumulator value |
| flag_o | output | 1 | Next flag value |
| ext_o | output | WIDTH | Upper half of product |
| acc_we_o | output | 1 | Accumulator write-enable |
| flag_we_o | output | 1 | Flag write-enable |
| ext_we_o | output | 1 | Extension register write-enable |

## Verification
Most flag edges are hard to reach with uniform random operands. An increment only wraps when the accumulator is exactly 0xFF, a decrement only when it is 0x00, and a compare or subtract only lands on its equality boundary when both operands match. Uniform random operands reach each of these cases about once in 256 draws. To reach them reliably, the stimulus takes each random operand from a small set of edge values (0x00, 0x01, 0x7F, 0x80, 0xFF, or a copy of the other operand) one time in three. Directed cases also pin each wrap and each sign-copy boundary explicitly.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NONE = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_MUL  = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_CMP  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_SHL  = 4'd9,
    OP_SHR  = 4'd10,
    OP_ROR  = 4'd11,
    OP_ROL  = 4'd12,
    OP_SAR  = 4'd13,
    OP_PASS = 4'd14,
    OP_RSVD = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
// Single shared adder for add, subtract, compare, increment and decrement.
module alu_addsub
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             cf
);
  localparam int SW = WIDTH + 1;

  logic [WIDTH-1:0] bsel;
  logic             cin;
  logic             inv;
  logic [SW-1:0]    wide;

  always_comb begin
    bsel = b;
    cin  = 1'b0;
    inv  = 1'b0;
    case (op)
      OP_SUB, OP_CMP: begin bsel = ~b;         cin = 1'b1; inv = 1'b1; end
      OP_INC:         begin bsel = '0;         cin = 1'b1; inv = 1'b0; end
      OP_DEC:         begin bsel = '1;         cin = 1'b0; inv = 1'b1; end
      default:        begin bsel = b;          cin = 1'b0; inv = 1'b0; end
    endcase
  end

  // Borrow is the inverted carry of a + ~b + 1 (or a + all-ones).
  assign wide = {1'b0, a} + {1'b0, bsel} + {{WIDTH{1'b0}}, cin};
  assign sum  = wide[WIDTH-1:0];
  assign cf   = wide[WIDTH] ^ inv;
endmodule

// File: rtl/alu_shift.sv
// Shift and rotate forms of the accumulator.
module alu_shift
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  output logic [WIDTH-1:0] res
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    case (op)
      OP_SHL:  res = {a[MSB-1:0], 1'b0};
      OP_SHR:  res = {1'b0, a[MSB:1]};
      OP_ROR:  res = {a[0], a[MSB:1]};
      OP_ROL:  res = {a[MSB-1:0], a[MSB]};
      OP_SAR:  res = {a[MSB], a[MSB:1]};
      default: res = a;
    endcase
  end
endmodule

// File: rtl/alu_mul.sv
// Unsigned full-width multiplier, product split into low and high halves.
module alu_mul #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] lo,
  output logic [WIDTH-1:0] hi
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0] prod;

  assign prod = {{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b};
  assign lo   = prod[WIDTH-1:0];
  assign hi   = prod[PW-1:WIDTH];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] reg_i,
  input  logic             flag_i,
  output logic [WIDTH-1:0] acc_o,
  output logic             flag_o,
  output logic [WIDTH-1:0] ext_o,
  output logic             acc_we_o,
  output logic             flag_we_o,
  output logic             ext_we_o
);
  alu_op_e          op;
  logic [WIDTH-1:0] as_sum, sh_res, mul_lo, mul_hi;
  logic             as_cf;

  logic [WIDTH-1:0] n_acc, n_ext;
  logic             n_flag, n_awe, n_fwe, n_ewe;

  assign op = alu_op_e'(op_i);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .op(op), .a(acc_i), .b(reg_i), .sum(as_sum), .cf(as_cf)
  );

  alu_shift #(.WIDTH(WIDTH)) u_shift (
    .op(op), .a(acc_i), .res(sh_res)
  );

  alu_mul #(.WIDTH(WIDTH)) u_mul (
    .a(acc_i), .b(reg_i), .lo(mul_lo), .hi(mul_hi)
  );

  // Result select: untouched destinations echo their inputs, ext reads zero.
  always_comb begin
    n_acc  = acc_i;
    n_flag = flag_i;
    n_ext  = '0;
    n_awe  = 1'b0;
    n_fwe  = 1'b0;
    n_ewe  = 1'b0;
    case (op)
      OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
        n_acc = as_sum; n_flag = as_cf; n_awe = 1'b1; n_fwe = 1'b1;
      end
      OP_CMP: begin
        n_flag = as_cf; n_fwe = 1'b1;
      end
      OP_MUL: begin
        n_acc = mul_lo; n_ext = mul_hi; n_awe = 1'b1; n_ewe = 1'b1;
      end
      OP_AND: begin
        n_acc = acc_i & reg_i; n_awe = 1'b1;
      end
      OP_XOR: begin
        n_acc = acc_i ^ reg_i; n_awe = 1'b1;
      end
      OP_SHL, OP_SHR, OP_ROR, OP_ROL, OP_SAR: begin
        n_acc = sh_res; n_awe = 1'b1;
      end
      OP_PASS: begin
        n_acc = reg_i; n_awe = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o     <= '0;
      flag_o    <= 1'b0;
      ext_o     <= '0;
      acc_we_o  <= 1'b0;
      flag_we_o <= 1'b0;
      ext_we_o  <= 1'b0;
    end else begin
      acc_o     <= n_acc;
      flag_o    <= n_flag;
      ext_o     <= n_ext;
      acc_we_o  <= n_awe;
      flag_we_o <= n_fwe;
      ext_we_o  <= n_ewe;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!acc_we_o && !flag_we_o && !ext_we_o && acc_o == '0 && ext_o == '0));

  // R4
  mul_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_MUL) |=> (acc_we_o && ext_we_o && !flag_we_o));

  // R6
  cmp_flag_only_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CMP) |=> (!acc_we_o && flag_we_o && !ext_we_o &&
                          flag_o == $past(acc_i < reg_i)));

  // R8
  shift_keeps_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SHL || op_i == OP_SHR || op_i == OP_ROR || op_i == OP_ROL || op_i == OP_SAR)
    |=> (acc_we_o && !flag_we_o && !ext_we_o));

  // R12
  unknown_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NONE || op_i == OP_RSVD) |=> (!acc_we_o && !flag_we_o && !ext_we_o));

  // R13
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flag_we_o || flag_o == $past(flag_i)));

  // R13
  ext_zero_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ext_we_o || ext_o == '0));
endmodule

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;
  typedef struct packed {
    logic [7:0] acc;
    logic       flag;
    logic [7:0] ext;
    logic       awe;
    logic       fwe;
    logic       ewe;
  } res_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_i = 4'd0;
  logic [7:0] acc_i = 8'd0;
  logic [7:0] reg_i = 8'd0;
  logic       flag_i = 1'b0;
  logic [7:0] acc_o, ext_o;
  logic       flag_o, acc_we_o, flag_we_o, ext_we_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  acc_alu #(.WIDTH(8)) uut (
    .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .reg_i(reg_i),
    .flag_i(flag_i), .acc_o(acc_o), .flag_o(flag_o), .ext_o(ext_o),
    .acc_we_o(acc_we_o), .flag_we_o(flag_we_o), .ext_we_o(ext_we_o)
  );

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6: return "R6";
      4'd7, 4'd8: return "R7";
      4'd9, 4'd10: return "R8";
      4'd11, 4'd12: return "R9";
      4'd13: return "R10";
      4'd14: return "R11";
      default: return "R12";
    endcase
  endfunction

  // Expected outputs per the requirements (R13 defaults for unwritten ones).
  function automatic res_t model(input logic [3:0] op, input logic [7:0] a,
                                 input logic [7:0] b, input logic f);
    res_t r;
    logic [15:0] p;
    r = '{acc: a, flag: f, ext: 8'h00, awe: 1'b0, fwe: 1'b0, ewe: 1'b0};
    case (op)
      4'd1: begin r.acc = a + b; r.flag = (int'(a) + int'(b)) > 255; r.awe = 1; r.fwe = 1; end
      4'd2: begin r.acc = a - b; r.flag = (b > a); r.awe = 1; r.fwe = 1; end
      4'd3: begin p = 16'(a) * 16'(b); r.acc = p[7:0]; r.ext = p[15:8]; r.awe = 1; r.ewe = 1; end
      4'd4: begin r.acc = a & b; r.awe = 1; end
      4'd5: begin r.acc = a ^ b; r.awe = 1; end
      4'd6: begin r.flag = (a < b); r.fwe = 1; end
      4'd7: begin r.acc = a + 8'd1; r.flag = (a == 8'hFF); r.awe = 1; r.fwe = 1; end
      4'd8: begin r.acc = a - 8'd1; r.flag = (a == 8'h00); r.awe = 1; r.fwe = 1; end
      4'd9:  begin r.acc = a << 1; r.awe = 1; end
      4'd10: begin r.acc = a >> 1; r.awe = 1; end
      4'd11: begin r.acc = {a[0], a[7:1]}; r.awe = 1; end
      4'd12: begin r.acc = {a[6:0], a[7]}; r.awe = 1; end
      4'd13: begin r.acc = {a[7], a[7:1]}; r.awe = 1; end
      4'd14: begin r.acc = b; r.awe = 1; end
      default: ;
    endcase
    return r;
  endfunction

  task automatic compare(input string tag, input res_t exp);
    res_t act;
    act = '{acc: acc_o, flag: flag_o, ext: ext_o, awe: acc_we_o, fwe: flag_we_o, ewe: ext_we_o};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: acc=%h flag=%b ext=%h we=%b%b%b expected acc=%h flag=%b ext=%h we=%b%b%b",
               tag, act.acc, act.flag, act.ext, act.awe, act.fwe, act.ewe,
               exp.acc, exp.flag, exp.ext, exp.awe, exp.fwe, exp.ewe);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic f);
    @(negedge clk);
    op_i = op; acc_i = a; reg_i = b; flag_i = f;
    @(negedge clk);
    compare(req_of(op), model(op, a, b, f));
  endtask

  function automatic logic [7:0] pick(input logic [7:0] other);
    int sel;
    if (($urandom % 3) != 0) return 8'($urandom);
    sel = int'($urandom % 6);
    case (sel)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h7F;
      3: return 8'h80;
      4: return 8'hFF;
      default: return other;
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    // R1: reset state, with busy inputs
    op_i = 4'd3; acc_i = 8'hFF; reg_i = 8'hFF; flag_i = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1", '{acc: 8'h00, flag: 1'b0, ext: 8'h00, awe: 1'b0, fwe: 1'b0, ewe: 1'b0});
    rst = 1'b0;

    // Directed corners
    run_op(4'd1, 8'hFF, 8'h01, 1'b0);  // R2 carry out
    run_op(4'd1, 8'h7F, 8'h01, 1'b1);  // R2 no carry
    run_op(4'd2, 8'h00, 8'h01, 1'b0);  // R3 borrow
    run_op(4'd2, 8'h42, 8'h42, 1'b1);  // R3 equal, no borrow
    run_op(4'd3, 8'hFF, 8'hFF, 1'b1);  // R4 FE01, flag kept
    run_op(4'd4, 8'hF0, 8'h3C, 1'b1);  // R5
    run_op(4'd5, 8'hF0, 8'h3C, 1'b0);  // R5
    run_op(4'd6, 8'h10, 8'h10, 1'b1);  // R6 equal -> 0
    run_op(4'd6, 8'h0F, 8'h10, 1'b0);  // R6 less -> 1
    run_op(4'd7, 8'hFF, 8'h00, 1'b0);  // R7 wrap up
    run_op(4'd7, 8'h7F, 8'h00, 1'b1);  // R7 no wrap
    run_op(4'd8, 8'h00, 8'h00, 1'b0);  // R7 wrap down
    run_op(4'd8, 8'h01, 8'h00, 1'b1);  // R7 no wrap
    run_op(4'd9, 8'h81, 8'h00, 1'b1);  // R8
    run_op(4'd10, 8'h81, 8'h00, 1'b0); // R8
    run_op(4'd11, 8'h01, 8'h00, 1'b1); // R9
    run_op(4'd12, 8'h80, 8'h00, 1'b0); // R9
    run_op(4'd13, 8'h80, 8'h00, 1'b1); // R10 sign copy
    run_op(4'd13, 8'h7E, 8'h00, 1'b0); // R10 positive
    run_op(4'd14, 8'h11, 8'hA5, 1'b1); // R11
    run_op(4'd0, 8'h12, 8'h34, 1'b1);  // R12 code 0, R13 echoes
    run_op(4'd15, 8'h56, 8'h78, 1'b0); // R12 code 15

    // Constrained random mix, R13 covered by every comparison
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a, b;
      a = 8'($urandom);
      b = pick(a);
      a = pick(b);
      run_op(4'($urandom), a, b, 1'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule